// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a synchronous burst memory. A single steering input decides, on each enabled clock edge, whether a fresh external address is captured or whether the current burst moves on by one beat. Only the lowest address bits take part in the burst. The upper bits keep the value they had when the address was captured. After four beats the burst wraps back to its first beat.

A static order input picks how the beats are visited. Linear order adds the beat number to the captured low bits. Interleaved order XORs the beat number into them. The operation type (read or write) is latched when the address is captured and is repeated on every later beat of that burst. A global stall input freezes the whole sequencer. When a capture happens while the select indication is low, the sequencer goes idle. From that state, advance requests are ignored until the next selected capture.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `active` is 0, `beatIdx` is 0, `opWrite` is 0 and `lastBeat` is 0.
- R2: On an edge with `stall` low, `advance` low and `select` high, the external address is captured. From the next cycle, `arrAddr` equals that address, `beatIdx` is 0 and `active` is 1.
- R3: With `interleave` low (linear order), beat n drives the two low address bits to (captured low bits + n) mod 4. The upper bits equal the captured upper bits.
- R4: With `interleave` high (interleaved order), beat n drives the two low address bits to (captured low bits XOR n). The upper bits are unchanged.
- R5: On an edge with `stall` low, `advance` high and `active` 1, `beatIdx` increments by one. From beat 3 it wraps to 0, and the address returns to the captured address.
- R6: `lastBeat` is 1 exactly when `active` is 1 and `beatIdx` is 3.
- R7: `opWrite` takes the value of `writeReq` (1 = write, 0 = read) at a capture. Advance edges ignore `writeReq` and keep `opWrite`.
- R8: While `stall` is high, `arrAddr`, `beatIdx`, `opWrite`, `active` and `lastBeat` keep their values, whatever the other inputs do.
- R9: A capture edge with `select` low clears `active`. While `active` is 0, advance edges change neither `active` nor `beatIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | 1 freezes the sequencer for this edge |
| advance | input | 1 | 0 = capture new address, 1 = step the burst |
| interleave | input | 1 | Beat order: 1 interleaved, 0 linear (static) |
| select | input | 1 | 1 = access selected at capture, 0 = deselect |
| writeReq | input | 1 | Operation at capture: 1 write, 0 read |
| extAddr | input | ADDR_W | External address |
| arrAddr | output | ADDR_W | Current array address |
| opWrite | output | 1 | Operation type of the current burst |
| active | output | 1 | A burst is in progress |
| beatIdx | output | BURST_BITS | Current beat number |
| lastBeat | output | 1 | Final beat of the burst |

## Verification
A stall can arrive in the same cycle as a capture request or an advance request. In that case, the freeze must win over both. The bench holds `stall` high while it drives a capture with a different address and `writeReq`, and again while it requests an advance. It then checks that the address, beat, operation type and active flag all stay put. A second collision also matters: an advance while idle, with a live `writeReq`. The bench checks that this starts no burst and leaves the operation type as it was.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic loadEn;
    logic deselEn;
    logic stepEn;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stall,
  input  logic        advance,
  input  logic        select,
  output seqStrobes_t strb,
  output logic        active
);
  logic enabled;
  assign enabled = !stall;

  always_comb begin
    strb.loadEn  = enabled && !advance && select;
    strb.deselEn = enabled && !advance && !select;
    strb.stepEn  = enabled && advance && active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             active <= 1'b0;
    else if (strb.loadEn)  active <= 1'b1;
    else if (strb.deselEn) active <= 1'b0;
  end
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobes_t           strb,
  input  logic                  active,
  input  logic                  interleave,
  input  logic                  writeReq,
  input  logic [ADDR_W-1:0]     extAddr,
  output logic [ADDR_W-1:0]     arrAddr,
  output logic                  opWrite,
  output logic [BURST_BITS-1:0] beatIdx,
  output logic                  lastBeat
);
  localparam int UPPER_W = ADDR_W - BURST_BITS;
  localparam logic [BURST_BITS-1:0] LAST_BEAT = {BURST_BITS{1'b1}};

  logic [ADDR_W-1:0]     baseAddr;
  logic [BURST_BITS-1:0] beatCnt;
  logic [BURST_BITS-1:0] linLow;
  logic [BURST_BITS-1:0] intLow;
  logic [BURST_BITS-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      opWrite  <= 1'b0;
    end else if (strb.loadEn) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
      opWrite  <= writeReq;
    end else if (strb.stepEn) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  assign linLow = baseAddr[BURST_BITS-1:0] + beatCnt;

  for (genvar b = 0; b < BURST_BITS; b++) begin : g_xor
    assign intLow[b] = baseAddr[b] ^ beatCnt[b];
  end

  assign lowBits  = interleave ? intLow : linLow;
  assign arrAddr  = {baseAddr[ADDR_W-1 -: UPPER_W], lowBits};
  assign beatIdx  = beatCnt;
  assign lastBeat = active && (beatCnt == LAST_BEAT);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stall,
  input  logic                  advance,
  input  logic                  interleave,
  input  logic                  select,
  input  logic                  writeReq,
  input  logic [ADDR_W-1:0]     extAddr,
  output logic [ADDR_W-1:0]     arrAddr,
  output logic                  opWrite,
  output logic                  active,
  output logic [BURST_BITS-1:0] beatIdx,
  output logic                  lastBeat
);
  seqStrobes_t strb;

  burst_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stall   (stall),
    .advance (advance),
    .select  (select),
    .strb    (strb),
    .active  (active)
  );

  burst_seq_datapath #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .active     (active),
    .interleave (interleave),
    .writeReq   (writeReq),
    .extAddr    (extAddr),
    .arrAddr    (arrAddr),
    .opWrite    (opWrite),
    .beatIdx    (beatIdx),
    .lastBeat   (lastBeat)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  stall,
  input logic                  advance,
  input logic                  select,
  input logic [ADDR_W-1:0]     extAddr,
  input logic [ADDR_W-1:0]     arrAddr,
  input logic                  opWrite,
  input logic                  active,
  input logic [BURST_BITS-1:0] beatIdx
);
  localparam logic [BURST_BITS-1:0] LAST_BEAT = {BURST_BITS{1'b1}};

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !advance && select) |=>
      (active && beatIdx == '0 && arrAddr == $past(extAddr)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && advance && active && beatIdx == LAST_BEAT) |=> (beatIdx == '0));

  p_keep_op_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && advance) |=> $stable(opWrite));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(arrAddr) && $stable(opWrite) &&
               $stable(beatIdx) && $stable(active)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && advance && !active) |=> (!active && $stable(beatIdx)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BURST_BITS (BURST_BITS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .stall   (stall),
  .advance (advance),
  .select  (select),
  .extAddr (extAddr),
  .arrAddr (arrAddr),
  .opWrite (opWrite),
  .active  (active),
  .beatIdx (beatIdx)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic          stall, advance, interleave, select, writeReq;
  logic [AW-1:0] extAddr;
  logic [AW-1:0] arrAddr;
  logic          opWrite, active, lastBeat;
  logic [1:0]    beatIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) dut_i (
    .clk(clk), .rstN(rstN), .stall(stall), .advance(advance),
    .interleave(interleave), .select(select), .writeReq(writeReq),
    .extAddr(extAddr), .arrAddr(arrAddr), .opWrite(opWrite),
    .active(active), .beatIdx(beatIdx), .lastBeat(lastBeat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, return at the next negedge.
  task automatic step(input logic st, input logic adv, input logic sel,
                      input logic wr, input logic [AW-1:0] a);
    stall = st; advance = adv; select = sel; writeReq = wr; extAddr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] base,
                                            input int n, input logic il);
    logic [1:0] lo;
    lo = il ? (base[1:0] ^ 2'(n)) : 2'(base[1:0] + 2'(n));
    return {base[AW-1:2], lo};
  endfunction

  task automatic t_reset();
    check("R1 active", 32'(active), 0);
    check("R1 beatIdx", 32'(beatIdx), 0);
    check("R1 opWrite", 32'(opWrite), 0);
    check("R1 lastBeat", 32'(lastBeat), 0);
  endtask

  task automatic t_burst(input logic il, input logic [AW-1:0] base, input logic wr);
    interleave = il;
    step(0, 0, 1, wr, base);
    check("R2 active", 32'(active), 1);
    check("R2 addr", 32'(arrAddr), 32'(base));
    check("R7 op captured", 32'(opWrite), 32'(wr));
    for (int n = 1; n <= 4; n++) begin
      step(0, 1, 1, ~wr, ~base);
      check(il ? "R4 addr" : "R3 addr", 32'(arrAddr), 32'(expAddr(base, n % 4, il)));
      check("R5 beat", 32'(beatIdx), 32'(n % 4));
      check("R6 last", 32'(lastBeat), 32'((n % 4) == 3));
      check("R7 op kept", 32'(opWrite), 32'(wr));
    end
    check("R5 wrap addr", 32'(arrAddr), 32'(base));
  endtask

  task automatic t_stall();
    logic [AW-1:0] a0;
    interleave = 0;
    step(0, 0, 1, 1, 20'h0F0F1);
    step(0, 1, 1, 0, '0);
    a0 = arrAddr;
    step(1, 0, 1, 0, 20'h33332);
    check("R8 addr on capture", 32'(arrAddr), 32'(a0));
    check("R8 op", 32'(opWrite), 1);
    step(1, 1, 1, 0, '0);
    check("R8 beat", 32'(beatIdx), 1);
    check("R8 addr on advance", 32'(arrAddr), 32'(a0));
    step(1, 0, 0, 0, '0);
    check("R8 active", 32'(active), 1);
  endtask

  task automatic t_deselect();
    logic [1:0] b0;
    logic [AW-1:0] a0;
    step(0, 0, 1, 0, 20'h55555);
    step(0, 1, 1, 0, '0);
    step(0, 0, 0, 0, 20'h11111);
    check("R9 desel", 32'(active), 0);
    b0 = beatIdx;
    a0 = arrAddr;
    step(0, 1, 1, 1, 20'h22222);
    check("R9 idle active", 32'(active), 0);
    check("R9 idle beat", 32'(beatIdx), 32'(b0));
    check("R9 idle addr", 32'(arrAddr), 32'(a0));
    check("R9 idle op", 32'(opWrite), 0);
    check("R6 idle last", 32'(lastBeat), 0);
    step(0, 0, 1, 1, 20'h44447);
    check("R9 reload", 32'(active), 1);
    check("R9 reload addr", 32'(arrAddr), 32'h44447);
  endtask

  initial begin
    rstN = 0; stall = 0; advance = 1; interleave = 0; select = 0;
    writeReq = 0; extAddr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_burst(0, 20'h12346, 1);
    t_burst(1, 20'hABCD1, 0);
    t_burst(1, 20'h00003, 1);
    t_burst(0, 20'hFFFFF, 0);
    t_stall();
    t_deselect();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule